// File: doc/BRIEF.md
# Pixel Column Hit Readout with Timestamp Buffering

This block is the digital readout of one column of a hybrid pixel detector. Every pixel watches its own discriminator bit. It records the value of a shared 7-bit crossing counter at the clock edge where the bit first goes high. It records the counter again at the edge where the bit first goes low. The pair of values gives both the arrival time of the hit and its time over threshold.

A priority scan picks finished hits, lowest row first, and moves at most one per clock into a bank of 24 end-of-column slots. Each move frees the pixel for a new hit. A slot keeps its hit until the hit's age, measured against the running counter modulo 128, equals a programmable latency. If the trigger input is high in that cycle, the hit is queued for output. If it is not, the hit is thrown away. Queued hits leave the block one per clock as records of row, leading timestamp and time over threshold.

When every slot is busy, finished hits stay in their pixels. A pixel that sees a new leading edge before its old hit was moved drops the old hit, and the block counts such losses.

Top module: `pcr_column_top`

## Requirements
- R1: After reset, `rec_valid` is 0 and `lost_hits` is 0, and no record appears while no discriminator bit has pulsed.
- R2: A pixel stores the `tstamp` value present at the rising clock edge where its discriminator is first seen high (leading time). It stores the `tstamp` value at the edge where the discriminator is first seen low (trailing time). Only then is the hit ready for the scan.
- R3: An emitted record carries the row index in `rec_row`, the leading time in `rec_lead`, and in `rec_tot` the value (trailing minus leading) modulo 128, which wraps correctly across the counter rollover.
- R4: The scan moves at most one ready hit per clock into a slot, choosing the lowest row index among ready pixels. The moved pixel is cleared and can record a later hit.
- R5: A stored hit is examined at the edge where (`tstamp` − leading time) mod 128 equals `latency`. If `trig` is 1 at that edge, the record is presented with `rec_valid` = 1 two edges later, when no other record is waiting. A `trig` at any other edge has no effect on that hit.
- R6: A stored hit whose examination edge sees `trig` = 0 is discarded and never appears at the output.
- R7: Several records accepted at the same edge leave one per clock on consecutive cycles, in ascending slot order. Slots are filled lowest free index first, so hits scanned into an empty bank leave in ascending row order.
- R8: The bank holds exactly 24 hits. With all 24 slots occupied, further ready hits remain in their pixels and move in once a slot is released.
- R9: A new leading edge on a pixel whose finished hit has not yet been moved replaces that hit with the new one, and `lost_hits` increases by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per crossing |
| rst | input | 1 | Synchronous active-high reset |
| disc | input | 160 | Discriminator bit of each pixel, bit index equals row |
| tstamp | input | 7 | Column-wide crossing counter |
| trig | input | 1 | Trigger accept for hits whose age equals the latency this cycle |
| latency | input | 7 | Age in crossings at which a stored hit is examined |
| rec_valid | output | 1 | A hit record is present this cycle |
| rec_row | output | 8 | Row index of the record |
| rec_lead | output | 7 | Leading-edge timestamp of the record |
| rec_tot | output | 7 | Time over threshold, trailing minus leading modulo 128 |
| lost_hits | output | 16 | Count of hits overwritten inside a pixel before transfer |

## Verification
A corrupted pixel timestamp or a wrong slot age surfaces as a record with the wrong lead or tot value, or as a record that arrives two edges off its trigger. That error is visible within one latency period of the hit. A slot that is never released shows up only once the bank fills: a later hit then never leaves its pixel, so its record is missing, and a second pulse on that pixel raises `lost_hits` too early. Scan or drain order faults appear immediately as records out of row order, or as gaps in what should be a run of back-to-back records.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int TS_W   = 7;
    localparam int PIX_N  = 160;
    localparam int SLOT_N = 24;
    localparam int ROW_W  = $clog2(PIX_N);
    localparam int LOST_W = 16;

    typedef enum logic [1:0] {
        PX_IDLE = 2'd0,
        PX_HIGH = 2'd1,
        PX_DONE = 2'd2
    } pix_st_e;

    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_WAIT  = 2'd1,
        SL_SEND  = 2'd2
    } slot_st_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [TS_W-1:0]  lead;
        logic [TS_W-1:0]  tot;
    } hit_t;

    function automatic logic [TS_W-1:0] ts_sub(input logic [TS_W-1:0] a,
                                               input logic [TS_W-1:0] b);
        return a - b;
    endfunction

endpackage

// File: rtl/pcr_prio.sv
module pcr_prio #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pcr_pixel.sv
module pcr_pixel
    import pcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            disc,
    input  logic [TS_W-1:0] ts,
    input  logic            clr,
    output logic            ready,
    output logic [TS_W-1:0] lead,
    output logic [TS_W-1:0] trail,
    output logic            ovw
);
    pix_st_e st;
    logic    disc_q;
    logic    rise;
    logic    fall;

    assign rise  = disc & ~disc_q;
    assign fall  = ~disc & disc_q;
    assign ready = (st == PX_DONE);
    assign ovw   = (st == PX_DONE) && rise && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PX_IDLE;
            disc_q <= 1'b0;
            lead   <= '0;
            trail  <= '0;
        end else begin
            disc_q <= disc;
            unique case (st)
                PX_IDLE: if (rise) begin
                    lead <= ts;
                    st   <= PX_HIGH;
                end
                PX_HIGH: if (fall) begin
                    trail <= ts;
                    st    <= PX_DONE;
                end
                PX_DONE: if (rise) begin
                    lead <= ts;
                    st   <= PX_HIGH;
                end else if (clr) begin
                    st <= PX_IDLE;
                end
                default: st <= PX_IDLE;
            endcase
        end
    end

    // R2: a pixel becomes ready only after its discriminator was seen falling
    a_r2_ready_after_fall: assert property (@(posedge clk) disable iff (rst)
        (st == PX_DONE && $past(st) == PX_HIGH) |-> $past(disc_q && !disc));

    // R4: a cleared pixel is idle on the next cycle unless a new edge arrived
    a_r4_clear_to_idle: assert property (@(posedge clk) disable iff (rst)
        (clr && ready && !rise) |=> (st == PX_IDLE));

endmodule

// File: rtl/pcr_slot_bank.sv
module pcr_slot_bank
    import pcr_pkg::*;
#(
    parameter int NSLOT = SLOT_N,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  hit_t            wr_hit,
    input  logic [TS_W-1:0] ts,
    input  logic [TS_W-1:0] latency,
    input  logic            trig,
    output logic            full,
    output logic            out_valid,
    output hit_t            out_hit
);
    slot_st_e         st   [NSLOT];
    hit_t             data [NSLOT];
    logic [NSLOT-1:0] free_v;
    logic [NSLOT-1:0] send_v;
    logic [NSLOT-1:0] due_v;
    logic             free_any;
    logic [SW-1:0]    free_idx;
    logic             send_any;
    logic [SW-1:0]    send_idx;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            free_v[i] = (st[i] == SL_EMPTY);
            send_v[i] = (st[i] == SL_SEND);
            due_v[i]  = (st[i] == SL_WAIT) && (ts_sub(ts, data[i].lead) == latency);
        end
    end

    pcr_prio #(.N(NSLOT), .IW(SW)) u_free (.req(free_v), .found(free_any), .idx(free_idx));
    pcr_prio #(.N(NSLOT), .IW(SW)) u_send (.req(send_v), .found(send_any), .idx(send_idx));

    assign full = !free_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                st[i]   <= SL_EMPTY;
                data[i] <= '0;
            end
            out_valid <= 1'b0;
            out_hit   <= '0;
        end else begin
            out_valid <= send_any;
            if (send_any) out_hit <= data[send_idx];
            for (int i = 0; i < NSLOT; i++) begin
                if (send_any && send_idx == SW'(i)) begin
                    st[i] <= SL_EMPTY;
                end else if (due_v[i]) begin
                    st[i] <= trig ? SL_SEND : SL_EMPTY;
                end else if (wr_en && free_any && free_idx == SW'(i)) begin
                    st[i]   <= SL_WAIT;
                    data[i] <= wr_hit;
                end
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        // R5: a slot only becomes queued for output when the trigger was present
        a_r5_send_needs_trig: assert property (@(posedge clk) disable iff (rst)
            (st[g] == SL_SEND && $past(st[g]) == SL_WAIT) |-> $past(trig));
        // R6: a waiting slot released without output had no trigger
        a_r6_drop_without_trig: assert property (@(posedge clk) disable iff (rst)
            (st[g] == SL_EMPTY && $past(st[g]) == SL_WAIT) |-> !$past(trig));
    end

    // R7: the output register only carries a record when a queued slot existed
    a_r7_out_from_queue: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(send_any));

endmodule

// File: rtl/pcr_column_top.sv
module pcr_column_top
    import pcr_pkg::*;
#(
    parameter int NPIX  = PIX_N,
    parameter int NSLOT = SLOT_N,
    localparam int CW   = $clog2(NPIX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIX-1:0]   disc,
    input  logic [TS_W-1:0]   tstamp,
    input  logic              trig,
    input  logic [TS_W-1:0]   latency,
    output logic              rec_valid,
    output logic [ROW_W-1:0]  rec_row,
    output logic [TS_W-1:0]   rec_lead,
    output logic [TS_W-1:0]   rec_tot,
    output logic [LOST_W-1:0] lost_hits
);
    logic [NPIX-1:0]  ready_v;
    logic [NPIX-1:0]  grant_v;
    logic [NPIX-1:0]  ovw_v;
    logic [TS_W-1:0]  lead_a  [NPIX];
    logic [TS_W-1:0]  trail_a [NPIX];
    logic             scan_any;
    logic [ROW_W-1:0] scan_idx;
    logic             bank_full;
    logic             move;
    hit_t             mv_hit;
    hit_t             rec;
    logic [CW-1:0]    n_ovw;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        pcr_pixel u_pix (
            .clk   (clk),
            .rst   (rst),
            .disc  (disc[p]),
            .ts    (tstamp),
            .clr   (grant_v[p]),
            .ready (ready_v[p]),
            .lead  (lead_a[p]),
            .trail (trail_a[p]),
            .ovw   (ovw_v[p])
        );
    end

    pcr_prio #(.N(NPIX), .IW(ROW_W)) u_scan (.req(ready_v), .found(scan_any), .idx(scan_idx));

    assign move = scan_any && !bank_full;

    always_comb begin
        grant_v = '0;
        if (move) grant_v[scan_idx] = 1'b1;
        mv_hit.row  = scan_idx;
        mv_hit.lead = lead_a[scan_idx];
        mv_hit.tot  = ts_sub(trail_a[scan_idx], lead_a[scan_idx]);
    end

    pcr_slot_bank #(.NSLOT(NSLOT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (move),
        .wr_hit    (mv_hit),
        .ts        (tstamp),
        .latency   (latency),
        .trig      (trig),
        .full      (bank_full),
        .out_valid (rec_valid),
        .out_hit   (rec)
    );

    assign rec_row  = rec.row;
    assign rec_lead = rec.lead;
    assign rec_tot  = rec.tot;

    always_comb begin
        n_ovw = '0;
        for (int i = 0; i < NPIX; i++) n_ovw = n_ovw + CW'(ovw_v[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) lost_hits <= '0;
        else     lost_hits <= lost_hits + LOST_W'(n_ovw);
    end

    // R4: at most one pixel is cleared per clock
    a_r4_one_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_v));
    // R4: only pixels holding a finished hit are cleared
    a_r4_grant_ready: assert property (@(posedge clk) disable iff (rst)
        (grant_v & ~ready_v) == '0);
    // R8: a full bank holds hits back in the pixels
    a_r8_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        bank_full |-> (grant_v == '0));
    // R9: the loss counter only moves after an overwrite in some pixel
    a_r9_lost_step: assert property (@(posedge clk) disable iff (rst)
        (lost_hits != $past(lost_hits)) |-> $past(|ovw_v));

endmodule

// File: tb/sim_pcr_column_top.sv
module sim_pcr_column_top;
    import pcr_pkg::*;

    typedef struct {
        int row;
        int lead;
        int tot;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PIX_N-1:0]  disc = '0;
    logic [TS_W-1:0]   tstamp = '0;
    logic              trig = 1'b0;
    logic [TS_W-1:0]   latency = 7'd20;
    logic              rec_valid;
    logic [ROW_W-1:0]  rec_row;
    logic [TS_W-1:0]   rec_lead;
    logic [TS_W-1:0]   rec_tot;
    logic [LOST_W-1:0] lost_hits;

    int   checks = 0;
    int   errors = 0;
    int   n_out  = 0;
    int   pcyc   = 0;
    int   t_trig = 0;
    bit   done   = 0;
    exp_t exp_q[$];
    int   out_cyc[$];

    always #2 clk = ~clk;

    pcr_column_top u0 (
        .clk(clk), .rst(rst), .disc(disc), .tstamp(tstamp), .trig(trig),
        .latency(latency), .rec_valid(rec_valid), .rec_row(rec_row),
        .rec_lead(rec_lead), .rec_tot(rec_tot), .lost_hits(lost_hits)
    );

    always @(posedge clk) pcyc <= pcyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        tstamp = tstamp + 7'd1;
        trig   = 1'b0;
    endtask

    task automatic wait_ts(input logic [TS_W-1:0] target);
        while (tstamp != target) step();
    endtask

    task automatic expect_hit(input int row, input int lead, input int tot);
        exp_t e;
        e.row = row; e.lead = lead & 127; e.tot = tot & 127;
        exp_q.push_back(e);
    endtask

    task automatic fire(input logic [TS_W-1:0] at);
        wait_ts(at);
        trig   = 1'b1;
        t_trig = pcyc;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rec_valid) begin
            n_out++;
            out_cyc.push_back(pcyc);
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected record row", int'(rec_row), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(rec_row) == e.row, "R4/R7 record row", int'(rec_row), e.row);
                chk(int'(rec_lead) == e.lead, "R2 leading time", int'(rec_lead), e.lead);
                chk(int'(rec_tot) == e.tot, "R3 time over threshold", int'(rec_tot), e.tot);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [TS_W-1:0] a;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        step();
        // R1: reset state
        chk(rec_valid == 1'b0, "R1 valid after reset", int'(rec_valid), 0);
        chk(lost_hits == '0, "R1 loss count after reset", int'(lost_hits), 0);
        repeat (10) step();
        chk(n_out == 0, "R1 no record without hits", n_out, 0);

        // R2 R3 R5: single hit, row 10
        latency = 7'd20;
        a = tstamp + 7'd2;
        wait_ts(a); disc[10] = 1'b1;
        wait_ts(a + 7'd5); disc[10] = 1'b0;
        expect_hit(10, int'(a), 5);
        fire(a + 7'd20);
        step(); step(); step();
        chk(n_out == 1, "R5 record count after trigger", n_out, 1);
        chk(out_cyc.size() > 0 && out_cyc[0] == t_trig + 2, "R5 record timing",
            out_cyc.size() > 0 ? out_cyc[0] : -1, t_trig + 2);

        // R4: same pixel reused after clearing
        a = tstamp + 7'd1;
        wait_ts(a); disc[10] = 1'b1;
        wait_ts(a + 7'd3); disc[10] = 1'b0;
        expect_hit(10, int'(a), 3);
        fire(a + 7'd20);
        repeat (3) step();
        chk(n_out == 2, "R4 reused pixel produced record", n_out, 2);

        // R5 R6: no trigger at the due edge, triggers off by one edge
        a = tstamp + 7'd1;
        wait_ts(a); disc[20] = 1'b1;
        wait_ts(a + 7'd4); disc[20] = 1'b0;
        fire(a + 7'd19);
        step();
        step();
        trig = 1'b1;
        repeat (10) step();
        chk(n_out == 2, "R6 dropped hit not emitted", n_out, 2);

        // R4 R7: rows 5 and 3 finish together, same leading time
        a = tstamp + 7'd1;
        wait_ts(a); disc[5] = 1'b1; disc[3] = 1'b1;
        wait_ts(a + 7'd2); disc[5] = 1'b0; disc[3] = 1'b0;
        expect_hit(3, int'(a), 2);
        expect_hit(5, int'(a), 2);
        fire(a + 7'd20);
        repeat (4) step();
        chk(n_out == 4, "R7 both records emitted", n_out, 4);
        chk(out_cyc[3] - out_cyc[2] == 1, "R7 back to back", out_cyc[3] - out_cyc[2], 1);

        // R3: time over threshold across counter rollover
        latency = 7'd30;
        wait_ts(7'd122); disc[40] = 1'b1;
        wait_ts(7'd7);   disc[40] = 1'b0;
        expect_hit(40, 122, 13);
        fire(7'd24);
        repeat (3) step();
        chk(n_out == 5, "R3 rollover record emitted", n_out, 5);

        // R8 R9: fill all slots, hold a hit in its pixel, overwrite it
        latency = 7'd100;
        a = tstamp + 7'd2;
        wait_ts(a); disc[23:0] = '1;
        wait_ts(a + 7'd2); disc[23:0] = '0;
        wait_ts(a + 7'd10); disc[30] = 1'b1;
        wait_ts(a + 7'd12); disc[30] = 1'b0;
        wait_ts(a + 7'd40); disc[30] = 1'b1;
        step();
        chk(lost_hits == 16'd1, "R9 overwrite counted", int'(lost_hits), 1);
        wait_ts(a + 7'd45); disc[30] = 1'b0;
        for (int r = 0; r < 24; r++) expect_hit(r, int'(a), 2);
        expect_hit(30, int'(a) + 40, 5);
        wait_ts(a + 7'd90);
        chk(n_out == 5, "R8 nothing emitted while waiting", n_out, 5);
        fire(a + 7'd100);
        base = n_out;
        repeat (30) step();
        chk(n_out == base + 24, "R8 all 24 slots held hits", n_out, base + 24);
        chk(out_cyc[base + 23] - out_cyc[base] == 23, "R7 one record per clock",
            out_cyc[base + 23] - out_cyc[base], 23);
        fire(a + 7'd140);
        repeat (4) step();
        chk(n_out == base + 25, "R8 held hit moved after slot freed", n_out, base + 25);
        chk(lost_hits == 16'd1, "R9 single loss recorded", int'(lost_hits), 1);
        chk(exp_q.size() == 0, "R5 all expected records seen", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule